// File: doc/BRIEF.md
# Flash Rewrite Mode Controller

This block sits between a CPU and a small on-chip flash array. The array is modelled as registers. The CPU rewrites the array by sending commands over a valid/ready command channel. Each command carries an opcode, a block index, a word index and a data byte.

Two commands run for many cycles: program and erase. There are two erase variants, one for a single block and one for every unlocked user block. The remaining commands take effect in the cycle they are accepted: read-status, read-array, clear-status, lock and unlock. Reads use a plain combinational port. That port returns either an array word or a status byte, depending on the current read mode.

The controller runs in one of two rewrite modes, chosen per command by the `ew_mode` pin.
- **Mode 0:** the CPU keeps running during a long operation and polls for status. When the operation ends, the read port shows status.
- **Mode 1:** `hold` stalls the CPU for the whole operation, and when it ends the read port returns to array data. Commands that would damage the block holding the rewrite program are refused. The read-status command is illegal, so status is seen only on the status pins.

The top blocks of the array form a boot area that no command may alter. Each user block has a lock bit. The lock-disable pin overrides all lock bits.

Top module: `flash_rewrite_ctrl`

## Requirements
- R1: After reset the array holds all ones and every lock bit is 1 (unlocked). The read port is in array mode. `st_ready` and `cmd_ready` are 1. `hold` and all error flags are 0.
- R2: A program command keeps `st_ready` and `cmd_ready` low for exactly 16 cycles. It then stores the old word ANDed with the data.
- R3: A program whose data has a 1 where the stored word has a 0 sets the sticky `st_prog_err`. The stored result is still old AND data.
- R4: A block-erase command keeps `st_ready` low for exactly 64 cycles. It then sets every word of the block to all ones.
- R5: Program, block-erase, lock and unlock aimed at a boot block (index >= USER_BLOCKS, blocks 6 and 7 by default) are refused. A refused command sets the sticky `st_cmd_err`, starts no operation and leaves the array unchanged.
- R6: When a program or erase finishes, the read port switches to status mode if the operation was started in mode 0, and to array mode if it was started in mode 1.
- R7: `hold` is 1 for every busy cycle of an operation started in mode 1. It is never 1 for an operation started in mode 0.
- R8: In mode 1, program and block-erase aimed at the block named by `prog_block` are refused with `st_cmd_err`. In mode 0 the same commands are accepted.
- R9: Erase-all erases every user block whose lock bit is 1, or every user block when `lock_disable` is 1. In mode 1 it is refused with `st_cmd_err` if the lock bit of `prog_block` is 1 or if `lock_disable` is 1.
- R10: In mode 0, read-status switches the read port to a status byte. Bit 7 of the byte is ready, bit 5 is erase error, bit 4 is program error, bit 3 is command error, and the other bits are 0. In mode 1, read-status is refused with `st_cmd_err` and the read mode is left as it was.
- R11: Lock clears a user block's lock bit to 0 and unlock sets it to 1. While `lock_disable` is 0, a program or block-erase aimed at a locked block starts no operation and leaves the array unchanged. Program sets `st_prog_err` and erase sets `st_erase_err`.
- R12: Clear-status clears all three error flags and leaves the read mode unchanged. Read-array switches the read port to array words.
- R13: The `cmd_op` codes are: 0 read-array, 1 read-status, 2 clear-status, 3 program, 4 block-erase, 5 erase-all, 6 lock, 7 unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ew_mode | input | 1 | Rewrite mode applied to the command being accepted (0 or 1) |
| prog_block | input | BLK_W | Block holding the rewrite program |
| lock_disable | input | 1 | 1 makes all lock bits ineffective |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken; low while an operation runs |
| cmd_op | input | 3 | Opcode (R13) |
| cmd_block | input | BLK_W | Target block |
| cmd_word | input | WRD_W | Target word in block (program) |
| cmd_data | input | DATA_W | Program data |
| rd_block | input | BLK_W | Read block address |
| rd_word | input | WRD_W | Read word address |
| rd_data | output | DATA_W | Array word, or status byte in status mode |
| hold | output | 1 | CPU stall during a mode-1 operation |
| st_ready | output | 1 | 1 when no operation is running |
| st_erase_err | output | 1 | Sticky erase error |
| st_prog_err | output | 1 | Sticky program error |
| st_cmd_err | output | 1 | Sticky refused-command flag |

A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both 1. While an operation runs, `cmd_ready` is low. During that time the sender must hold its command stable, with `cmd_valid` still high, until the command is taken.

## Verification
The hardest case to reach is mode-1 erase-all with a locked program block. Several earlier steps must all be in place. The program block must hold data, another block must be locked and hold data, and a third block must be unlocked and hold data. The two refusal paths must also have been driven: an unlocked program block, and lock-disable set.

The stimulus builds that state step by step through the command port:
1. A table of vectors first fills and erases blocks in both modes.
2. Directed steps then run a mode-0 erase-all, reprogram the affected blocks, and lock the program block.
3. Finally, mode-1 erase-all is issued once with `lock_disable` set and once with it cleared. Each word is read back through the array read port.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;

  typedef enum logic [2:0] {
    OP_RD_ARRAY  = 3'd0,
    OP_RD_STATUS = 3'd1,
    OP_CLR_STAT  = 3'd2,
    OP_PROGRAM   = 3'd3,
    OP_ERASE_BLK = 3'd4,
    OP_ERASE_ALL = 3'd5,
    OP_LOCK      = 3'd6,
    OP_UNLOCK    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    KIND_PROG = 2'd0,
    KIND_BLK  = 2'd1,
    KIND_ALL  = 2'd2
  } kind_e;

  typedef struct packed {
    logic start_prog;
    logic start_blk;
    logic start_all;
    logic err_cmd;
    logic err_prog;
    logic err_erase;
    logic go_status;
    logic go_array;
    logic clr_status;
    logic lock_wr;
    logic lock_val;
  } verdict_t;

endpackage

// File: rtl/flash_cmd_check.sv
module flash_cmd_check
  import flash_rw_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int USER_BLOCKS = 6,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  op_e                   op,
  input  logic [BLK_W-1:0]      block,
  input  logic                  mode1,
  input  logic [BLK_W-1:0]      prog_block,
  input  logic                  lock_disable,
  input  logic [NUM_BLOCKS-1:0] locks,
  output verdict_t              verdict
);

  logic in_boot;
  logic writable;
  logic guarded;

  assign in_boot  = (block >= BLK_W'(USER_BLOCKS));
  assign writable = lock_disable | locks[block];
  assign guarded  = mode1 & (block == prog_block);

  always_comb begin
    verdict = '0;
    unique case (op)
      OP_RD_ARRAY:  verdict.go_array = 1'b1;
      OP_RD_STATUS: begin
        if (mode1) verdict.err_cmd   = 1'b1;
        else       verdict.go_status = 1'b1;
      end
      OP_CLR_STAT:  verdict.clr_status = 1'b1;
      OP_PROGRAM: begin
        if (in_boot || guarded) verdict.err_cmd    = 1'b1;
        else if (!writable)     verdict.err_prog   = 1'b1;
        else                    verdict.start_prog = 1'b1;
      end
      OP_ERASE_BLK: begin
        if (in_boot || guarded) verdict.err_cmd   = 1'b1;
        else if (!writable)     verdict.err_erase = 1'b1;
        else                    verdict.start_blk = 1'b1;
      end
      OP_ERASE_ALL: begin
        if (mode1 && (locks[prog_block] || lock_disable)) verdict.err_cmd = 1'b1;
        else                                              verdict.start_all = 1'b1;
      end
      OP_LOCK, OP_UNLOCK: begin
        if (in_boot) verdict.err_cmd = 1'b1;
        else begin
          verdict.lock_wr  = 1'b1;
          verdict.lock_val = (op == OP_UNLOCK);
        end
      end
      default: verdict = '0;
    endcase
  end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W = $clog2(MAXC) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_op,
  output logic busy,
  output logic done
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= long_op ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign done = busy && (remain == '0);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int NUM_BLOCKS = 8,
  parameter int WORDS      = 4,
  parameter int DATA_W     = 8,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int WRD_W  = $clog2(WORDS),
  localparam int IDX_W  = BLK_W + WRD_W,
  localparam int TOTAL  = NUM_BLOCKS * WORDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic                  is_prog,
  input  logic [BLK_W-1:0]      wr_block,
  input  logic [WRD_W-1:0]      wr_word,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_BLOCKS-1:0] erase_mask,
  input  logic [BLK_W-1:0]      rd_block,
  input  logic [WRD_W-1:0]      rd_word,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  prog_bad
);

  logic [TOTAL*DATA_W-1:0] cells;
  logic [IDX_W-1:0]        wr_idx;
  logic [IDX_W-1:0]        rd_idx;
  logic [DATA_W-1:0]       cur_word;

  assign wr_idx   = {wr_block, wr_word};
  assign rd_idx   = {rd_block, rd_word};
  assign cur_word = cells[wr_idx*DATA_W +: DATA_W];
  assign rd_data  = cells[rd_idx*DATA_W +: DATA_W];
  assign prog_bad = |(wr_data & ~cur_word);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    for (genvar w = 0; w < WORDS; w++) begin : g_wrd
      localparam int IDX = b * WORDS + w;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cells[IDX*DATA_W +: DATA_W] <= '1;
        end else if (commit) begin
          if (is_prog) begin
            if (wr_idx == IDX_W'(IDX))
              cells[IDX*DATA_W +: DATA_W] <= cells[IDX*DATA_W +: DATA_W] & wr_data;
          end else if (erase_mask[b]) begin
            cells[IDX*DATA_W +: DATA_W] <= '1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/flash_rewrite_ctrl.sv
module flash_rewrite_ctrl
  import flash_rw_pkg::*;
#(
  parameter int NUM_BLOCKS   = 8,
  parameter int USER_BLOCKS  = 6,
  parameter int WORDS        = 4,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ew_mode,
  input  logic [BLK_W-1:0]  prog_block,
  input  logic              lock_disable,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_block,
  input  logic [WRD_W-1:0]  cmd_word,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [BLK_W-1:0]  rd_block,
  input  logic [WRD_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              hold,
  output logic              st_ready,
  output logic              st_erase_err,
  output logic              st_prog_err,
  output logic              st_cmd_err
);

  verdict_t              verdict;
  logic                  accept;
  logic                  start;
  logic                  busy;
  logic                  done;
  logic                  prog_bad;
  logic [NUM_BLOCKS-1:0] locks;
  logic [NUM_BLOCKS-1:0] all_mask;
  logic [NUM_BLOCKS-1:0] one_mask;
  logic [NUM_BLOCKS-1:0] mask_q;
  kind_e                 kind_q;
  logic [BLK_W-1:0]      blk_q;
  logic [WRD_W-1:0]      wrd_q;
  logic [DATA_W-1:0]     data_q;
  logic                  mode_q;
  logic                  status_view;
  logic [DATA_W-1:0]     arr_word;
  logic [7:0]            status_byte;

  assign accept    = cmd_valid & cmd_ready;
  assign start     = accept & (verdict.start_prog | verdict.start_blk | verdict.start_all);
  assign cmd_ready = ~busy;
  assign st_ready  = ~busy;
  assign hold      = busy & mode_q;

  flash_cmd_check #(.NUM_BLOCKS(NUM_BLOCKS), .USER_BLOCKS(USER_BLOCKS)) u_decide (
    .op           (op_e'(cmd_op)),
    .block        (cmd_block),
    .mode1        (ew_mode),
    .prog_block   (prog_block),
    .lock_disable (lock_disable),
    .locks        (locks),
    .verdict      (verdict)
  );

  flash_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .long_op (~verdict.start_prog),
    .busy    (busy),
    .done    (done)
  );

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_mask
    assign all_mask[g] = (g < USER_BLOCKS) && (locks[g] || lock_disable);
    assign one_mask[g] = (cmd_block == BLK_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= KIND_PROG;
      blk_q  <= '0;
      wrd_q  <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
      mask_q <= '0;
    end else if (start) begin
      kind_q <= verdict.start_prog ? KIND_PROG : (verdict.start_blk ? KIND_BLK : KIND_ALL);
      blk_q  <= cmd_block;
      wrd_q  <= cmd_word;
      data_q <= cmd_data;
      mode_q <= ew_mode;
      mask_q <= verdict.start_all ? all_mask : one_mask;
    end
  end

  flash_cell_array #(.NUM_BLOCKS(NUM_BLOCKS), .WORDS(WORDS), .DATA_W(DATA_W)) u_cells (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (done),
    .is_prog    (kind_q == KIND_PROG),
    .wr_block   (blk_q),
    .wr_word    (wrd_q),
    .wr_data    (data_q),
    .erase_mask (mask_q),
    .rd_block   (rd_block),
    .rd_word    (rd_word),
    .rd_data    (arr_word),
    .prog_bad   (prog_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locks        <= '1;
      status_view  <= 1'b0;
      st_erase_err <= 1'b0;
      st_prog_err  <= 1'b0;
      st_cmd_err   <= 1'b0;
    end else begin
      if (accept) begin
        if (verdict.clr_status) begin
          st_erase_err <= 1'b0;
          st_prog_err  <= 1'b0;
          st_cmd_err   <= 1'b0;
        end
        if (verdict.err_cmd)   st_cmd_err   <= 1'b1;
        if (verdict.err_prog)  st_prog_err  <= 1'b1;
        if (verdict.err_erase) st_erase_err <= 1'b1;
        if (verdict.go_status) status_view  <= 1'b1;
        if (verdict.go_array)  status_view  <= 1'b0;
        if (verdict.lock_wr)   locks[cmd_block] <= verdict.lock_val;
      end
      if (done) begin
        if (kind_q == KIND_PROG && prog_bad) st_prog_err <= 1'b1;
        status_view <= ~mode_q;
      end
    end
  end

  assign status_byte = {st_ready, 1'b0, st_erase_err, st_prog_err, st_cmd_err, 3'b000};
  assign rd_data     = status_view ? DATA_W'(status_byte) : arr_word;

endmodule

// File: rtl/flash_rewrite_ctrl_chk.sv
module flash_rewrite_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ew_mode,
  input logic       lock_disable,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       hold,
  input logic       st_ready,
  input logic       st_erase_err,
  input logic       st_prog_err,
  input logic       st_cmd_err
);

  logic acc;
  assign acc = cmd_valid & cmd_ready;

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !st_ready);

  p_mode0_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ew_mode) |=> !hold);

  p_busy_blocks_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> !cmd_ready);

  p_status_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd1 && ew_mode) |=> (st_cmd_err && st_ready));

  p_all_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd5 && ew_mode && lock_disable) |=> (st_cmd_err && st_ready));

  p_clear_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd2) |=> (!st_cmd_err && !st_prog_err && !st_erase_err));

endmodule

bind flash_rewrite_ctrl flash_rewrite_ctrl_chk u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .ew_mode      (ew_mode),
  .lock_disable (lock_disable),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .hold         (hold),
  .st_ready     (st_ready),
  .st_erase_err (st_erase_err),
  .st_prog_err  (st_prog_err),
  .st_cmd_err   (st_cmd_err)
);

// File: tb/flash_rewrite_ctrl_test.sv
module flash_rewrite_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ew_mode = 1'b0;
  logic [2:0] prog_block = 3'd0;
  logic       lock_disable = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_block = 3'd0;
  logic [1:0] cmd_word = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic [2:0] rd_block = 3'd0;
  logic [1:0] rd_word = 2'd0;
  logic [7:0] rd_data;
  logic       hold, st_ready, st_erase_err, st_prog_err, st_cmd_err;

  int checks = 0;
  int fails  = 0;
  int busy_n, hold_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rewrite_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ew_mode(ew_mode), .prog_block(prog_block),
    .lock_disable(lock_disable), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_block(cmd_block), .cmd_word(cmd_word), .cmd_data(cmd_data),
    .rd_block(rd_block), .rd_word(rd_word), .rd_data(rd_data), .hold(hold),
    .st_ready(st_ready), .st_erase_err(st_erase_err), .st_prog_err(st_prog_err),
    .st_cmd_err(st_cmd_err)
  );

  // op codes (R13)
  localparam logic [2:0] RDA = 3'd0, RDS = 3'd1, CLR = 3'd2, PRG = 3'd3,
                         ERB = 3'd4, ERA = 3'd5, LCK = 3'd6, ULK = 3'd7;

  // {op, block, word, data, mode, flags(ready,erase,prog,cmd), word read back}
  localparam int NV = 11;
  localparam logic [28:0] TBL [0:NV-1] = '{
    {PRG, 3'd1, 2'd0, 8'hA5, 1'b0, 4'b1000, 8'hA5},
    {PRG, 3'd1, 2'd0, 8'h0F, 1'b0, 4'b1010, 8'h05},
    {PRG, 3'd1, 2'd0, 8'h01, 1'b0, 4'b1000, 8'h01},
    {ERB, 3'd1, 2'd0, 8'h00, 1'b0, 4'b1000, 8'hFF},
    {PRG, 3'd6, 2'd0, 8'h00, 1'b0, 4'b1001, 8'hFF},
    {ERB, 3'd7, 2'd0, 8'h00, 1'b0, 4'b1001, 8'hFF},
    {PRG, 3'd2, 2'd3, 8'h3C, 1'b1, 4'b1000, 8'h3C},
    {PRG, 3'd0, 2'd1, 8'h00, 1'b1, 4'b1001, 8'hFF},
    {PRG, 3'd0, 2'd1, 8'h00, 1'b0, 4'b1000, 8'h00},
    {ERB, 3'd0, 2'd1, 8'h00, 1'b1, 4'b1001, 8'h00},
    {RDS, 3'd2, 2'd3, 8'h00, 1'b1, 4'b1001, 8'h3C}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    busy_n = 0;
    hold_n = 0;
    while (!st_ready && busy_n < 1000) begin
      busy_n++;
      if (hold) hold_n++;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [2:0] blk,
                      input logic [1:0] wrd, input logic [7:0] dat);
    cmd_op = op; cmd_block = blk; cmd_word = wrd; cmd_data = dat;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  function automatic logic [7:0] read_at(input logic [2:0] b, input logic [1:0] w);
    return 8'h00;
  endfunction

  task automatic peek(input logic [2:0] b, input logic [1:0] w);
    rd_block = b; rd_word = w;
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd3, 2'd2);
    check(st_ready && cmd_ready && !hold, "R1 ready", {st_ready, cmd_ready, hold}, 3'b110);
    check({st_erase_err, st_prog_err, st_cmd_err} == 3'b000, "R1 flags",
          {st_erase_err, st_prog_err, st_cmd_err}, 0);
    check(rd_data == 8'hFF, "R1 array", rd_data, 8'hFF);

    // table walk (R2 R3 R4 R5 R8 R10 R13)
    for (int i = 0; i < NV; i++) begin
      ew_mode = 1'b0;
      send(CLR, 3'd0, 2'd0, 8'h00);
      ew_mode = TBL[i][12];
      send(TBL[i][28:26], TBL[i][25:23], TBL[i][22:21], TBL[i][20:13]);
      check({st_ready, st_erase_err, st_prog_err, st_cmd_err} == TBL[i][11:8],
            $sformatf("R13 vec%0d flags", i),
            {st_ready, st_erase_err, st_prog_err, st_cmd_err}, TBL[i][11:8]);
      send(RDA, 3'd0, 2'd0, 8'h00);
      peek(TBL[i][25:23], TBL[i][22:21]);
      check(rd_data == TBL[i][7:0], $sformatf("R5 R8 vec%0d word", i), rd_data, TBL[i][7:0]);
    end

    // R2 R6 R7 mode-0 program timing and status view
    ew_mode = 1'b0;
    send(CLR, 3'd0, 2'd0, 8'h00);
    send(PRG, 3'd5, 2'd2, 8'h77);
    check(busy_n == 16, "R2 program cycles", busy_n, 16);
    check(hold_n == 0, "R7 no hold mode0", hold_n, 0);
    peek(3'd5, 2'd2);
    check(rd_data == 8'h80, "R6 status view mode0", rd_data, 8'h80);

    // R4 R6 R7 mode-1 erase timing, hold, array view
    ew_mode = 1'b1;
    send(ERB, 3'd5, 2'd0, 8'h00);
    check(busy_n == 64, "R4 erase cycles", busy_n, 64);
    check(hold_n == 64, "R7 hold mode1", hold_n, 64);
    peek(3'd5, 2'd2);
    check(rd_data == 8'hFF, "R6 R4 array view mode1", rd_data, 8'hFF);

    // R10 R12 status byte layout and clear
    ew_mode = 1'b0;
    send(LCK, 3'd6, 2'd0, 8'h00);
    check(st_cmd_err == 1'b1, "R5 boot lock refused", st_cmd_err, 1);
    send(RDS, 3'd0, 2'd0, 8'h00);
    check(rd_data == 8'h88, "R10 status byte", rd_data, 8'h88);
    send(CLR, 3'd0, 2'd0, 8'h00);
    check(rd_data == 8'h80, "R12 clear keeps status view", rd_data, 8'h80);
    send(RDA, 3'd0, 2'd0, 8'h00);
    peek(3'd2, 2'd3);
    check(rd_data == 8'h3C, "R12 read array", rd_data, 8'h3C);

    // R11 locks
    send(LCK, 3'd3, 2'd0, 8'h00);
    send(PRG, 3'd3, 2'd0, 8'h00);
    check(busy_n == 0 && st_prog_err, "R11 locked program", {busy_n[0], st_prog_err}, 1);
    send(RDA, 3'd0, 2'd0, 8'h00);
    peek(3'd3, 2'd0);
    check(rd_data == 8'hFF, "R11 locked unchanged", rd_data, 8'hFF);
    lock_disable = 1'b1;
    send(PRG, 3'd3, 2'd0, 8'h00);
    lock_disable = 1'b0;
    send(RDA, 3'd0, 2'd0, 8'h00);
    peek(3'd3, 2'd0);
    check(rd_data == 8'h00, "R11 lock disable", rd_data, 8'h00);
    send(CLR, 3'd0, 2'd0, 8'h00);
    send(ERB, 3'd3, 2'd0, 8'h00);
    check(st_erase_err && !st_prog_err, "R11 locked erase", st_erase_err, 1);
    send(RDA, 3'd0, 2'd0, 8'h00);
    peek(3'd3, 2'd0);
    check(rd_data == 8'h00, "R11 erase blocked", rd_data, 8'h00);

    // R9 erase-all
    send(PRG, 3'd4, 2'd0, 8'h00);
    send(ERA, 3'd0, 2'd0, 8'h00);
    send(RDA, 3'd0, 2'd0, 8'h00);
    peek(3'd4, 2'd0);
    check(rd_data == 8'hFF, "R9 mode0 erases unlocked", rd_data, 8'hFF);
    peek(3'd3, 2'd0);
    check(rd_data == 8'h00, "R9 mode0 skips locked", rd_data, 8'h00);
    send(PRG, 3'd0, 2'd1, 8'h00);
    send(PRG, 3'd4, 2'd0, 8'h00);
    send(CLR, 3'd0, 2'd0, 8'h00);
    ew_mode = 1'b1;
    send(ERA, 3'd0, 2'd0, 8'h00);
    check(st_cmd_err && busy_n == 0, "R9 refused prog block unlocked", st_cmd_err, 1);
    send(LCK, 3'd0, 2'd0, 8'h00);
    send(CLR, 3'd0, 2'd0, 8'h00);
    lock_disable = 1'b1;
    send(ERA, 3'd0, 2'd0, 8'h00);
    lock_disable = 1'b0;
    check(st_cmd_err && busy_n == 0, "R9 refused lock disable", st_cmd_err, 1);
    send(CLR, 3'd0, 2'd0, 8'h00);
    send(ERA, 3'd0, 2'd0, 8'h00);
    check(busy_n == 64 && !st_cmd_err, "R9 mode1 accepted", busy_n, 64);
    peek(3'd4, 2'd0);
    check(rd_data == 8'hFF, "R9 mode1 erases", rd_data, 8'hFF);
    peek(3'd0, 2'd1);
    check(rd_data == 8'h00, "R9 prog block kept", rd_data, 8'h00);
    peek(3'd3, 2'd0);
    check(rd_data == 8'h00, "R9 locked kept", rd_data, 8'h00);

    // R11 unlock restores writes
    ew_mode = 1'b0;
    send(ULK, 3'd3, 2'd0, 8'h00);
    send(ERB, 3'd3, 2'd0, 8'h00);
    send(RDA, 3'd0, 2'd0, 8'h00);
    peek(3'd3, 2'd0);
    check(rd_data == 8'hFF, "R11 unlock", rd_data, 8'hFF);

    summary();
  end
endmodule